// File: doc/BRIEF.md
# Memory Region Fill Engine

This block is a self-test engine that writes a deterministic pattern into a contiguous region of memory. Software places a base address and a word count on plain control inputs, picks scrambled or plain data with a mode input, and pulses `start` for one cycle. The engine then sends one write command per word on a command channel. For each command it offers the matching pattern word on a separate write-data channel. When the last word has been accepted it raises `done`, which software polls.

Both channels are valid/ready. Once the engine raises a valid, it holds that valid and its payload steady until it samples ready high on a rising edge. The memory side may apply back-pressure for as long as it likes by holding ready low. Ready that arrives while valid is low has no effect. Only one transfer is open at a time. The command goes first, then its data beat, and the next command follows that beat.

Each data word is built from 32-bit chunks. Every chunk is derived from a seed taken from the word's offset within the region. In scrambled mode the seed goes through a multiply-and-add. In plain mode the seed is used as it is.

Top module: `mem_fill_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) returns the engine to idle: in the following cycle `done`, `cmd_valid` and `wd_valid` are low. This holds even when the reset arrives in the middle of a fill.
- R2: A `start` sampled high while idle with `length` > 0 raises `cmd_valid` in the next cycle, with `cmd_we` = 1 and `cmd_addr` = `base`.
- R3: The engine writes the addresses `base`, `base`+1, …, `base`+`length`−1 in that order, one command each. Addresses wrap modulo 2^ADDR_W.
- R4: `cmd_valid` and `cmd_addr` hold steady until `cmd_ready` is sampled high. `wd_valid` rises in the cycle after the command is accepted.
- R5: `wd_valid` and `wd_data` hold steady until `wd_ready` is sampled high. `cmd_valid` and `wd_valid` are never high together. The next command appears in the cycle after the data beat is accepted.
- R6: In scrambled mode (`scramble` = 1 at start), each chunk equals (seed × 0x31415979 + 1) mod 2^32.
- R7: In plain mode (`scramble` = 0 at start), each chunk equals its seed mod 2^32.
- R8: A word at offset k holds K = DATA_W/32 chunks. Chunk i uses seed k×K + i. Chunk 0 occupies bits [DATA_W−1 : DATA_W−32], and each later chunk sits 32 bits lower.
- R9: `done` rises in the cycle after the last data beat is accepted. It stays high until the next accepted `start`, and that `start` clears it at the same edge.
- R10: A `start` with `length` = 0 sets `done` in the next cycle and issues no command.
- R11: A `start` pulse while a fill is in progress is ignored.
- R12: `base`, `length` and `scramble` are captured at the accepted `start`. Changes to them during a fill have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a fill |
| base | input | ADDR_W | First word address of the region |
| length | input | LEN_W | Number of words to write |
| scramble | input | 1 | 1 = scrambled pattern, 0 = plain seed |
| done | output | 1 | High once the region has been written |
| cmd_valid | output | 1 | Write command offered |
| cmd_ready | input | 1 | Command accepted by the memory side |
| cmd_we | output | 1 | Write enable of the command, always 1 |
| cmd_addr | output | ADDR_W | Word address of the command |
| wd_valid | output | 1 | Write-data beat offered |
| wd_ready | input | 1 | Data beat accepted by the memory side |
| wd_data | output | DATA_W | Pattern word for the current address |

## Verification
Every output of the engine comes from a register. Each change is therefore due exactly one clock after the edge that sampled its cause. The first command follows the start edge by one cycle, the data beat follows command acceptance by one cycle, and the next command or `done` follows data acceptance by one cycle. The bench keeps a behavioural model that is stepped on each rising edge with the same sampled `start`, `rst` and ready values that the design sees. It drives inputs and compares every output against the model at the falling edge. Each mismatch is therefore caught in the exact cycle it appears. The ready inputs are stalled pseudo-randomly, and after each fill the bench also checks the written region against the pattern function.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int CHUNK_W = 32;
  localparam logic [CHUNK_W-1:0] SCRAMBLE_MUL = 32'h3141_5979;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } fill_state_t;
endpackage

// File: rtl/fill_chunk.sv
module fill_chunk
  import fill_pkg::*;
#(
  parameter int CHUNK_IDX = 0,
  parameter int CHUNKS    = 2
) (
  input  logic [CHUNK_W-1:0] word_idx,
  input  logic               scramble,
  output logic [CHUNK_W-1:0] chunk
);
  localparam logic [CHUNK_W-1:0] MUL_K = CHUNK_W'(CHUNKS);
  localparam logic [CHUNK_W-1:0] ADD_I = CHUNK_W'(CHUNK_IDX);

  logic [CHUNK_W-1:0] seed;

  always_comb begin
    seed  = word_idx * MUL_K + ADD_I;
    chunk = scramble ? (seed * SCRAMBLE_MUL + 32'd1) : seed;
  end
endmodule

// File: rtl/fill_pattern.sv
module fill_pattern
  import fill_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [CHUNK_W-1:0] word_idx,
  input  logic               scramble,
  output logic [DATA_W-1:0]  word
);
  localparam int CHUNKS = DATA_W / CHUNK_W;

  for (genvar i = 0; i < CHUNKS; i++) begin : g_chunk
    fill_chunk #(
      .CHUNK_IDX(i),
      .CHUNKS   (CHUNKS)
    ) u_chunk (
      .word_idx(word_idx),
      .scramble(scramble),
      .chunk   (word[DATA_W-1-CHUNK_W*i -: CHUNK_W])
    );
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  length,
  input  logic              scramble,
  input  logic              cmd_ready,
  input  logic              wd_ready,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wd_valid,
  output logic              done,
  output logic [LEN_W-1:0]  word_idx,
  output logic              mode
);
  fill_state_t       state;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last;

  assign last      = (word_idx == len_q - LEN_W'(1));
  assign cmd_valid = (state == ST_CMD);
  assign wd_valid  = (state == ST_DATA);
  assign cmd_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      word_idx <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      mode     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          done     <= (length == '0);
          word_idx <= '0;
          addr_q   <= base;
          len_q    <= length;
          mode     <= scramble;
          if (length != '0) state <= ST_CMD;
        end
        ST_CMD: if (cmd_ready) state <= ST_DATA;
        ST_DATA: if (wd_ready) begin
          if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            word_idx <= word_idx + LEN_W'(1);
            addr_q   <= addr_q + ADDR_W'(1);
            state    <= ST_CMD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)));
  a_r4_data_follows: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> wd_valid);
  a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(word_idx)));
  a_r5_one_channel: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && wd_valid));
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wd_valid && wd_ready && !done && cmd_valid == 1'b0 && !last) |=>
      (cmd_valid && cmd_addr == $past(cmd_addr) + ADDR_W'(1)));
  a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && length == '0) |=> (done && !cmd_valid));
  a_r11_busy_start: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && start) |=> (cmd_valid && !done));
endmodule

// File: rtl/mem_fill_engine.sv
module mem_fill_engine
  import fill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  length,
  input  logic              scramble,
  output logic              done,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [DATA_W-1:0] wd_data
);
  logic [LEN_W-1:0] word_idx;
  logic             mode;

  assign cmd_we = 1'b1;

  fill_seq #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .base     (base),
    .length   (length),
    .scramble (scramble),
    .cmd_ready(cmd_ready),
    .wd_ready (wd_ready),
    .cmd_valid(cmd_valid),
    .cmd_addr (cmd_addr),
    .wd_valid (wd_valid),
    .done     (done),
    .word_idx (word_idx),
    .mode     (mode)
  );

  fill_pattern #(
    .DATA_W(DATA_W)
  ) u_pat (
    .word_idx(CHUNK_W'(word_idx)),
    .scramble(mode),
    .word    (wd_data)
  );

  a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
    (wd_valid && !wd_ready) |=> $stable(wd_data));
  a_r2_write_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_we);
endmodule

// File: tb/mem_fill_engine_test.sv
module mem_fill_engine_test;
  localparam int AW = 12;
  localparam int LW = 10;
  localparam int DW = 64;
  localparam int K  = DW / 32;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [LW-1:0] length = '0;
  logic scramble = 1'b0;
  logic cmd_ready = 1'b0, wd_ready = 1'b0;
  logic done, cmd_valid, cmd_we, wd_valid;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wd_data;

  always #2 clk = ~clk;

  mem_fill_engine #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .start(start), .base(base), .length(length),
    .scramble(scramble), .done(done), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data));

  int tests = 0, fails = 0, cyc = 0;
  bit live = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model
  int m_ph = 0, m_idx = 0, m_base = 0, m_len = 0;
  bit m_scr = 0, m_done = 0;
  logic [DW-1:0] mem [int];
  int beats = 0, cur_addr = 0;

  function automatic logic [DW-1:0] pat(int unsigned idx, bit scr);
    logic [DW-1:0] r = '0;
    for (int c = 0; c < K; c++) begin
      int unsigned s = idx * K + c;
      logic [31:0] v = scr ? (s * 32'h31415979 + 1) : s;
      r[DW-1-32*c -: 32] = v;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    live <= 1;
    if (cmd_valid && cmd_ready) cur_addr = int'(cmd_addr);
    if (wd_valid && wd_ready) begin mem[cur_addr] = wd_data; beats++; end
    if (rst) begin
      m_ph <= 0; m_done <= 0; m_idx <= 0;
    end else case (m_ph)
      0: if (start) begin
        m_done <= (length == 0);
        m_idx <= 0; m_base <= int'(base); m_len <= int'(length); m_scr <= scramble;
        if (length != 0) m_ph <= 1;
      end
      1: if (cmd_ready) m_ph <= 2;
      default: if (wd_ready) begin
        if (m_idx == m_len - 1) begin m_ph <= 0; m_done <= 1; end
        else begin m_idx <= m_idx + 1; m_ph <= 1; end
      end
    endcase
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(done == m_done, "R9 done", DW'(done), DW'(m_done));
      chk(cmd_valid == (m_ph == 1), "R4 cmd_valid", DW'(cmd_valid), DW'(m_ph == 1));
      chk(wd_valid == (m_ph == 2), "R5 wd_valid", DW'(wd_valid), DW'(m_ph == 2));
      if (m_ph == 1) begin
        chk(int'(cmd_addr) == ((m_base + m_idx) & AMASK), "R3 cmd_addr",
            DW'(cmd_addr), DW'((m_base + m_idx) & AMASK));
        chk(cmd_we == 1'b1, "R2 cmd_we", DW'(cmd_we), 1);
      end
      if (m_ph == 2)
        chk(wd_data == pat(m_idx, m_scr), m_scr ? "R6 wd_data" : "R7 wd_data",
            wd_data, pat(m_idx, m_scr));
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cmd_ready = lfsr[0] | lfsr[5];
    wd_ready  = lfsr[3];
  end

  task automatic fill(int b, int l, bit scr, bit poke);
    int wait_n = 0;
    @(negedge clk);
    mem.delete(); beats = 0;
    base = AW'(b); length = LW'(l); scramble = scr; start = 1;
    @(negedge clk);
    start = 0;
    base = AW'(b + 77); length = 0; scramble = ~scr; // R12 ignored mid-run
    if (l == 0) chk(done && !cmd_valid, "R10 zero length", DW'({done, cmd_valid}), 2);
    else chk(cmd_valid && int'(cmd_addr) == b, "R2 first command", DW'(cmd_addr), DW'(b));
    if (poke) begin
      @(negedge clk); start = 1;   // R11 busy start
      @(negedge clk); start = 0;
    end
    while (!done && wait_n < 3000) begin @(negedge clk); wait_n++; end
    chk(beats == l, "R3 beat count", DW'(beats), DW'(l));
    for (int k = 0; k < l; k++) begin
      int a = (b + k) & AMASK;
      chk(mem.exists(a) && mem[a] == pat(k, scr), "R8 stored word",
          mem.exists(a) ? mem[a] : '0, pat(k, scr));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!done && !cmd_valid && !wd_valid, "R1 reset state", DW'({done, cmd_valid, wd_valid}), 0);
    fill(16'h100, 5, 1, 0);
    chk(pat(0, 1)[63:32] == 32'h1 && pat(0, 1)[31:0] == 32'h3141597A, "R8 chunk order", pat(0, 1), 64'h1_3141597A);
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R9 done held", DW'(done), 1);
    fill(16'h020, 4, 0, 0);
    fill(AMASK - 1, 4, 1, 0);
    fill(16'h300, 0, 1, 0);
    fill(16'h040, 6, 0, 1);
    fill(16'h055, 1, 1, 0);
    fill(16'h200, 12, 1, 0);
    // R1 reset in the middle of a fill
    @(negedge clk);
    base = 12'h400; length = 8; scramble = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    chk(!done && !cmd_valid && !wd_valid, "R1 mid-run reset", DW'({done, cmd_valid, wd_valid}), 0);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule